// File: doc/BRIEF.md
# Program Counter and Loop Stack Sequencer

This block holds the return-address and loop state of an instruction sequencer. A last-in first-out stack keeps return addresses for subroutine calls and interrupt entries. A second stack keeps one record per active counted or conditional loop, so loops can nest. Each loop record holds the iteration count, the address of the last instruction of the body, the address of the first instruction of the body, and the exit mode. The count and end-address halves are always pushed and popped together.

Each cycle the sequencer presents the current fetch address. When that address matches the end address of the innermost loop, the block decides whether the loop goes round again or finishes. If it goes round, it redirects fetch to the loop start and updates the count. If it finishes, it pops the loop record.

A return pops the call stack and hands back the popped address as the next fetch address in the same cycle. An interrupt request warns software one entry before the call stack is full. Any misuse of either stack sets a sticky error flag.

Top module: `pcloop_seq`

## Requirements
- R1: `push_call` pushes `push_addr` onto a return stack of PC_DEPTH (default 30) entries. `ret_addr` always shows the most recent entry that has not been popped, in last-in first-out order, and shows 0 when the stack is empty.
- R2: `pc_near_full_irq` is 1 exactly while the return stack holds at least PC_DEPTH-1 (default 29) entries.
- R3: When `pop_ret` is 1 and the return stack is not empty, `redirect` is 1 and `redirect_addr` equals the top entry in that same cycle. The entry is removed at the next clock edge.
- R4: A push onto a full stack (return stack or loop stack), or a `pop_ret` on an empty return stack, leaves the stack contents and depth unchanged and sets `seq_err`. A pop on the empty return stack does not assert `redirect`.
- R5: `seq_err` stays at 1 until reset, whatever the inputs do.
- R6: `loop_begin` pushes one record onto a loop stack of LOOP_DEPTH (default 6) entries. The record holds `loop_cnt`, `loop_end`, `loop_start` and `loop_mode`. `top_count` and `top_end` show the innermost record, and show 0 when the loop stack is empty. Finishing an inner loop exposes the enclosing one.
- R7: Count mode is `loop_mode`=0. When `fetch_addr` equals `top_end` and `top_count` is greater than 1, the block asserts `redirect` with `redirect_addr` set to the loop start, and `top_count` is one lower after the clock edge. When `top_count` is 0 or 1, `loop_exit` is 1 instead, with no redirect, and the record is popped at the clock edge.
- R8: Flag mode is `loop_mode`=1. At the end address the loop finishes exactly when the `cond_in` value sampled two clock edges earlier was 1. Otherwise the block redirects to the loop start, and `top_count` is left unchanged.
- R9: Priorities within one cycle. `pop_ret` takes precedence over `push_call`, and the push is dropped without an error. `pop_ret` or `loop_begin` suppresses loop-end handling in that cycle, so there is no `loop_exit`, no loop redirect, and no count change.
- R10: After reset both stacks are empty, `seq_err`, `pc_near_full_irq`, `loop_exit` and `redirect` are 0, and the `cond_in` history reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| push_call | input | 1 | Push a return address (call or interrupt entry) |
| push_addr | input | AW | Return address to push |
| pop_ret | input | 1 | Return: pop the return stack |
| loop_begin | input | 1 | Open a new loop |
| loop_mode | input | 1 | 0 = exit on count, 1 = exit on delayed flag |
| loop_cnt | input | CW | Iteration count of the new loop |
| loop_start | input | AW | First address of the loop body |
| loop_end | input | AW | Last address of the loop body |
| fetch_addr | input | AW | Current fetch address |
| cond_in | input | 1 | Condition flag for flag-mode loops |
| ret_addr | output | AW | Top of the return stack |
| redirect | output | 1 | Next fetch comes from `redirect_addr` |
| redirect_addr | output | AW | Redirected fetch address |
| top_count | output | CW | Count of the innermost loop |
| top_end | output | AW | End address of the innermost loop |
| loop_exit | output | 1 | Innermost loop finishes this cycle |
| pc_near_full_irq | output | 1 | Return stack is one entry from full, or full |
| seq_err | output | 1 | Sticky stack misuse flag |

## Verification
The hardest states to reach from the ports are the two depth boundaries. The near-full warning and the overflow refusal need 29 and then 31 successive pushes. A loop-stack overflow needs six live nested loops, all of which must later be retired one by one through end-address hits. The bench reaches these by filling each stack completely with address patterns it computes itself, then draining it entry by entry and checking each exposed record. The two-cycle flag delay is swept by placing a single true flag at every offset from the loop start. The bench then checks that the exit lands exactly two edges later.

// File: rtl/pcloop_pkg.sv
package pcloop_pkg;
  typedef enum logic {
    LOOP_BY_COUNT = 1'b0,
    LOOP_BY_FLAG  = 1'b1
  } loop_mode_e;
endpackage

// File: rtl/pcl_lifo.sv
module pcl_lifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         upd,
  input  logic [W-1:0] din,
  input  logic [W-1:0] upd_din,
  output logic [W-1:0] top,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic         empty,
  output logic         fault
);
  localparam int LW = $clog2(DEPTH+1);
  localparam int IW = $clog2(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [LW-1:0] lvl_q, lvl_d, top_pos, wr_pos;
  logic [W-1:0]  wr_data;
  logic          is_empty, is_full, do_push, do_pop, do_upd, wr_en;

  always_comb begin
    is_empty = (lvl_q == '0);
    is_full  = (lvl_q == LW'(DEPTH));
    do_pop   = pop && !is_empty;
    do_push  = push && !pop && !is_full;
    do_upd   = upd && !push && !pop && !is_empty;
    top_pos  = lvl_q - LW'(1);
    wr_pos   = do_push ? lvl_q : top_pos;
    wr_en    = do_push || do_upd;
    wr_data  = do_push ? din : upd_din;
    lvl_d    = lvl_q;
    if (do_pop)       lvl_d = lvl_q - LW'(1);
    else if (do_push) lvl_d = lvl_q + LW'(1);
    fault    = (pop && is_empty) || (push && !pop && is_full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_pos[IW-1:0]] <= wr_data;
  end

  assign top   = is_empty ? '0 : mem_q[top_pos[IW-1:0]];
  assign level = lvl_q;
  assign empty = is_empty;

  // R4: a refused push keeps the depth
  a_r4_full_push_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && lvl_q == LW'(DEPTH)) |=> (lvl_q == LW'(DEPTH)));
  // R4: a pop on empty keeps the stack empty
  a_r4_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && lvl_q == '0) |=> (lvl_q == '0));
  // R1: depth never exceeds capacity
  a_r1_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LW'(DEPTH));
  // R6: an accepted push grows the depth by one
  a_r6_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && lvl_q < LW'(DEPTH)) |=> (lvl_q == $past(lvl_q) + LW'(1)));
endmodule

// File: rtl/pcl_cond_delay.sv
module pcl_cond_delay #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q, sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = d;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pcloop_seq.sv
module pcloop_seq
  import pcloop_pkg::*;
#(
  parameter int AW         = 24,
  parameter int CW         = 16,
  parameter int PC_DEPTH   = 30,
  parameter int LOOP_DEPTH = 6,
  parameter int FLAG_DELAY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_call,
  input  logic [AW-1:0] push_addr,
  input  logic          pop_ret,
  input  logic          loop_begin,
  input  logic          loop_mode,
  input  logic [CW-1:0] loop_cnt,
  input  logic [AW-1:0] loop_start,
  input  logic [AW-1:0] loop_end,
  input  logic [AW-1:0] fetch_addr,
  input  logic          cond_in,
  output logic [AW-1:0] ret_addr,
  output logic          redirect,
  output logic [AW-1:0] redirect_addr,
  output logic [CW-1:0] top_count,
  output logic [AW-1:0] top_end,
  output logic          loop_exit,
  output logic          pc_near_full_irq,
  output logic          seq_err
);
  localparam int LEW       = 1 + 2*AW + CW;
  localparam int PLW       = $clog2(PC_DEPTH+1);
  localparam int LLW       = $clog2(LOOP_DEPTH+1);
  localparam int NEAR_FULL = PC_DEPTH - 1;

  logic [AW-1:0]  pc_top;
  logic [PLW-1:0] pc_level;
  logic           pc_empty, pc_fault;
  logic [LEW-1:0] lp_top, lp_new, lp_dec;
  logic [LLW-1:0] lp_level;
  logic           lp_empty, lp_fault;
  loop_mode_e     lp_mode;
  logic [AW-1:0]  lp_start, lp_end;
  logic [CW-1:0]  lp_cnt;
  logic           cond_old, quiet, at_end, done, lp_iter, lp_upd;
  logic           err_q, err_d;

  pcl_lifo #(.W(AW), .DEPTH(PC_DEPTH)) u_pc_stack (
    .clk(clk), .rst_n(rst_n), .push(push_call), .pop(pop_ret), .upd(1'b0),
    .din(push_addr), .upd_din('0), .top(pc_top), .level(pc_level),
    .empty(pc_empty), .fault(pc_fault));

  pcl_lifo #(.W(LEW), .DEPTH(LOOP_DEPTH)) u_loop_stack (
    .clk(clk), .rst_n(rst_n), .push(loop_begin), .pop(loop_exit), .upd(lp_upd),
    .din(lp_new), .upd_din(lp_dec), .top(lp_top), .level(lp_level),
    .empty(lp_empty), .fault(lp_fault));

  pcl_cond_delay #(.STAGES(FLAG_DELAY)) u_flag_dly (
    .clk(clk), .rst_n(rst_n), .d(cond_in), .q(cond_old));

  always_comb begin
    lp_new   = {loop_mode, loop_start, loop_end, loop_cnt};
    lp_mode  = loop_mode_e'(lp_top[LEW-1]);
    lp_start = lp_top[LEW-2 -: AW];
    lp_end   = lp_top[AW+CW-1 -: AW];
    lp_cnt   = lp_top[CW-1:0];
    lp_dec   = {lp_top[LEW-1:CW], lp_cnt - CW'(1)};
    quiet    = !pop_ret && !loop_begin;
    at_end   = quiet && !lp_empty && (fetch_addr == lp_end);
    done     = (lp_mode == LOOP_BY_FLAG) ? cond_old : (lp_cnt <= CW'(1));
    loop_exit = at_end && done;
    lp_iter  = at_end && !done;
    lp_upd   = lp_iter && (lp_mode == LOOP_BY_COUNT);
    redirect = (pop_ret && !pc_empty) || lp_iter;
    redirect_addr = pop_ret ? pc_top : lp_start;
    err_d    = err_q || pc_fault || lp_fault;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign ret_addr         = pc_top;
  assign top_count        = lp_cnt;
  assign top_end          = lp_end;
  assign pc_near_full_irq = (pc_level >= PLW'(NEAR_FULL));
  assign seq_err          = err_q;

  // R5: error flag never clears without reset
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);
  // R3: a valid return redirects to the stack top in the same cycle
  a_r3_ret_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ret && !pc_empty) |-> (redirect && redirect_addr == ret_addr));
  // R7: a finishing loop removes exactly one record
  a_r7_exit_pops: assert property (@(posedge clk) disable iff (!rst_n)
    loop_exit |=> (lp_level == $past(lp_level) - LLW'(1)));
  // R2: the warning can only rise after an accepted push
  a_r2_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pc_near_full_irq) |-> $past(push_call && !pop_ret));
  // R8: a flag-mode iteration keeps the count
  a_r8_flag_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_iter && lp_mode == LOOP_BY_FLAG) |=> $stable(top_count));
endmodule

// File: tb/sim_pcloop_seq.sv
module sim_pcloop_seq;
  localparam int AW = 24;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic push_call, pop_ret, loop_begin, loop_mode, cond_in;
  logic [AW-1:0] push_addr, loop_start, loop_end, fetch_addr;
  logic [CW-1:0] loop_cnt;
  logic [AW-1:0] ret_addr, redirect_addr, top_end;
  logic [CW-1:0] top_count;
  logic redirect, loop_exit, pc_near_full_irq, seq_err;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pcloop_seq u0 (
    .clk(clk), .rst_n(rst_n), .push_call(push_call), .push_addr(push_addr),
    .pop_ret(pop_ret), .loop_begin(loop_begin), .loop_mode(loop_mode),
    .loop_cnt(loop_cnt), .loop_start(loop_start), .loop_end(loop_end),
    .fetch_addr(fetch_addr), .cond_in(cond_in), .ret_addr(ret_addr),
    .redirect(redirect), .redirect_addr(redirect_addr), .top_count(top_count),
    .top_end(top_end), .loop_exit(loop_exit),
    .pc_near_full_irq(pc_near_full_irq), .seq_err(seq_err));

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic idle();
    push_call = 0; pop_ret = 0; loop_begin = 0; loop_mode = 0; cond_in = 0;
    push_addr = '0; loop_start = '0; loop_end = '0; fetch_addr = '0; loop_cnt = '0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] paddr(input int i);
    return AW'(24'h1000 + i * 24'h35);
  endfunction

  task automatic open_loop(input int cnt, input int e, input int s, input logic m);
    loop_begin = 1; loop_cnt = CW'(cnt); loop_end = AW'(e); loop_start = AW'(s); loop_mode = m;
    @(negedge clk);
    loop_begin = 0;
  endtask

  // Run a count-mode loop at end address e until it exits
  task automatic run_count(input int n, input int e, input int s);
    int iters = (n < 1) ? 1 : n;
    for (int j = 1; j <= iters; j++) begin
      fetch_addr = AW'(e);
      #1;
      chk(loop_exit, (j == iters), "R7 loop_exit");
      chk(redirect, (j != iters), "R7 redirect");
      if (j != iters) chk(redirect_addr, s, "R7 redirect_addr");
      chk(top_count, n - j + 1, "R7 top_count");
      @(negedge clk);
    end
    fetch_addr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    // R10 reset state
    #1;
    chk(seq_err, 0, "R10 seq_err");
    chk(pc_near_full_irq, 0, "R10 irq");
    chk(ret_addr, 0, "R10 ret_addr");
    chk(top_count, 0, "R10 top_count");
    chk(loop_exit, 0, "R10 loop_exit");
    chk(redirect, 0, "R10 redirect");

    // R1/R2 fill the return stack
    for (int i = 0; i < 30; i++) begin
      push_call = 1; push_addr = paddr(i);
      @(negedge clk);
      push_call = 0;
      #1;
      chk(ret_addr, paddr(i), "R1 ret_addr");
      chk(pc_near_full_irq, (i + 1 >= 29), "R2 irq");
    end
    // R4 overflow refused
    push_call = 1; push_addr = 24'hFFFFFF;
    @(negedge clk);
    push_call = 0;
    #1;
    chk(seq_err, 1, "R4 overflow err");
    chk(ret_addr, paddr(29), "R4 overflow keeps top");
    // R3 drain
    for (int k = 0; k < 30; k++) begin
      pop_ret = 1;
      #1;
      chk(redirect, 1, "R3 redirect");
      chk(redirect_addr, paddr(29 - k), "R3 redirect_addr");
      chk(pc_near_full_irq, (30 - k >= 29), "R2 irq drain");
      @(negedge clk);
      pop_ret = 0;
    end
    #1;
    chk(ret_addr, 0, "R1 empty ret_addr");
    pop_ret = 1;
    #1;
    chk(redirect, 0, "R4 empty pop no redirect");
    @(negedge clk);
    pop_ret = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(seq_err, 1, "R5 sticky");
    chk(ret_addr, 0, "R4 empty pop keeps empty");
    do_reset();
    #1;
    chk(seq_err, 0, "R10 err cleared");

    // R7 count loops of several lengths
    for (int n = 0; n <= 5; n++) begin
      open_loop(n, 24'h100 + n, 24'h0F0 + n, 1'b0);
      #1;
      chk(top_count, n, "R6 top_count");
      chk(top_end, 24'h100 + n, "R6 top_end");
      run_count(n, 24'h100 + n, 24'h0F0 + n);
      #1;
      chk(top_count, 0, "R7 popped");
    end

    // R6 nesting to full depth, then overflow
    for (int i = 0; i < 6; i++) begin
      open_loop(2, 24'h200 + i, 24'h180 + i, 1'b0);
      #1;
      chk(top_end, 24'h200 + i, "R6 nested top_end");
    end
    open_loop(4, 24'h2FF, 24'h2F0, 1'b0);
    #1;
    chk(seq_err, 1, "R4 loop overflow err");
    chk(top_end, 24'h205, "R4 loop overflow keeps top");
    for (int i = 5; i >= 0; i--) begin
      run_count(2, 24'h200 + i, 24'h180 + i);
      #1;
      chk(top_end, (i > 0) ? 24'h200 + i - 1 : 0, "R6 outer exposed");
    end
    do_reset();

    // R8 flag loops: a single true flag at offset k
    for (int k = 0; k <= 4; k++) begin
      cond_in = (k == 0);
      open_loop(7, 24'h300, 24'h2F0, 1'b1);
      cond_in = (k == 1);
      @(negedge clk);
      for (int n = 2; n <= k + 2; n++) begin
        cond_in = (n == k);
        fetch_addr = 24'h300;
        #1;
        chk(loop_exit, (n - 2 == k), "R8 flag exit");
        chk(redirect, (n - 2 != k), "R8 flag redirect");
        chk(top_count, 7, "R8 count kept");
        @(negedge clk);
      end
      fetch_addr = '0; cond_in = 0;
      #1;
      chk(top_count, 0, "R8 popped");
      @(negedge clk);
    end

    // R9 pop beats push
    push_call = 1; push_addr = 24'h77;
    @(negedge clk);
    push_addr = 24'h88; pop_ret = 1;
    #1;
    chk(redirect_addr, 24'h77, "R9 pop over push addr");
    @(negedge clk);
    push_call = 0; pop_ret = 0;
    #1;
    chk(ret_addr, 0, "R9 push dropped");
    chk(seq_err, 0, "R9 no error");

    // R9 loop_begin suppresses loop-end handling
    open_loop(1, 24'h400, 24'h3F0, 1'b0);
    fetch_addr = 24'h400;
    loop_begin = 1; loop_cnt = 3; loop_end = 24'h500; loop_start = 24'h4F0; loop_mode = 0;
    #1;
    chk(loop_exit, 0, "R9 begin suppresses exit");
    chk(redirect, 0, "R9 begin suppresses redirect");
    @(negedge clk);
    loop_begin = 0; fetch_addr = '0;
    #1;
    chk(top_end, 24'h500, "R9 new loop on top");
    run_count(3, 24'h500, 24'h4F0);
    #1;
    chk(top_end, 24'h400, "R9 outer loop kept");

    // R9 return beats loop end
    push_call = 1; push_addr = 24'h55;
    @(negedge clk);
    push_call = 0; pop_ret = 1; fetch_addr = 24'h400;
    #1;
    chk(redirect_addr, 24'h55, "R9 return addr wins");
    chk(loop_exit, 0, "R9 return suppresses exit");
    @(negedge clk);
    pop_ret = 0; fetch_addr = '0;
    #1;
    chk(top_end, 24'h400, "R9 loop untouched");
    chk(top_count, 1, "R9 count untouched");
    run_count(1, 24'h400, 24'h3F0);
    #1;
    chk(top_end, 0, "R7 final pop");
    chk(seq_err, 0, "R5 no spurious error");

    finish_run();
  end
endmodule